// File: doc/BRIEF.md
# MESI Snooping Coherence Controller

This block sits beside one private cache and moves a single line at a time between the four MESI states. Its first input stream carries local load, store, atomic read-modify-write and flush requests. Each request comes with the current state of the addressed line, read from the tag store. Its second input stream carries messages snooped from a shared bus, each with the snooped line's current state. The block sends bus messages of its own. It waits for the matching read response and for an invalidate acknowledgment from every peer cache. Only then does it write the new state back to the tag store and report completion.

While one local transition is outstanding, the block keeps answering snooped traffic for every address. A reply to a snoop always takes the transmit slot ahead of the local request message. When a snoop needs two replies, the receive port is held off for one cycle. The number of peer caches is a parameter and sets how many acknowledgments are needed.

Top module: `coh_ctrl`

## Requirements
- R1: After reset, `tx_valid`, `tag_wr_en` and `req_done` are 0 and `req_ready` and `rx_ready` are 1. Line states are coded I=0, S=1, E=2, M=3.
- R2: A load (`req_op`=0) to a line in I sends a read (message code 0) one cycle after acceptance. It completes one cycle after the read response (code 1) for that address is taken, and writes state S.
- R3: A store (`req_op`=1) to a line in E writes state M and pulses `req_done` one cycle after acceptance, with no bus message.
- R4: A store or atomic (`req_op`=2) to a line in I sends read-invalidate (code 4). It completes only after both the read response and `NPEER` invalidate acknowledgments (code 3) for that address have arrived, and then writes M.
- R5: A store or atomic to a line in S sends invalidate (code 2). It completes only after `NPEER` acknowledgments, and then writes M.
- R6: A snooped read-invalidate to a line in M or E gets a read response with `tx_data`=1 in the next cycle and an invalidate acknowledgment in the cycle after. The line is written I, and `rx_ready` is 0 between the two replies.
- R7: A snooped read to a line in M or E gets a read response with `tx_data`=1 and the line is written S. A snooped read to a line in S or I gets no reply.
- R8: A snooped invalidate to a line in S gets an invalidate acknowledgment in the next cycle and the line is written I.
- R9: A flush (`req_op`=3) of a line in M sends writeback (code 5) with `tx_data`=1 and writes E.
- R10: `req_ready` stays 0 from acceptance until the cycle of `req_done`. Acknowledgments and responses for other addresses do not count toward completion.
- R11: While a request is pending, snoops to other addresses are still answered. A snoop reply that competes with a local message is sent first, and the local message follows in the next cycle.
- R12: A load to a line in S, E or M, and an atomic to a line in M, complete one cycle after acceptance with no bus message and rewrite the same or M state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Local request present |
| req_op | input | 2 | 0 load, 1 store, 2 atomic, 3 flush |
| req_addr | input | ADDR_W | Line address of the local request |
| req_state | input | 2 | Current state of the requested line |
| req_ready | output | 1 | Controller idle, request can be accepted |
| req_done | output | 1 | One-cycle pulse when the transition completes |
| tag_wr_en | output | 1 | Tag-store state write strobe |
| tag_wr_addr | output | ADDR_W | Line address written |
| tag_wr_state | output | 2 | New line state |
| tx_valid | output | 1 | Bus message present |
| tx_msg | output | 3 | Bus message code |
| tx_addr | output | ADDR_W | Bus message line address |
| tx_data | output | 1 | Message carries line data |
| rx_valid | input | 1 | Snooped bus message present |
| rx_msg | input | 3 | Snooped message code |
| rx_addr | input | ADDR_W | Snooped line address |
| rx_state | input | 2 | Current local state of the snooped line |
| rx_ready | output | 1 | Snooped message can be taken this cycle |

## Verification
The hardest case to reach is a local transition that is waiting on the bus while unrelated traffic arrives. In that case, acknowledgments for another address must not be counted, and a snoop reply must displace the local message from the transmit slot. The bench starts a load miss and presents a snooped read on another address in the very cycle the local read would go out. It then checks that the reply goes first and the read follows. During a read-invalidate wait, it mixes stray acknowledgments for a foreign address with the real ones. It checks that completion waits for the last real acknowledgment and for the read response.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_t;

    typedef enum logic [2:0] {
        BM_RD     = 3'd0,
        BM_RDRSP  = 3'd1,
        BM_INV    = 3'd2,
        BM_INVACK = 3'd3,
        BM_RDINV  = 3'd4,
        BM_WB     = 3'd5
    } bus_msg_t;

    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_ATOMIC = 2'd2,
        OP_FLUSH  = 2'd3
    } loc_op_t;

    // What an accepted local request has to do before it may retire
    typedef struct packed {
        logic     send;
        bus_msg_t msg;
        logic     data;
        logic     want_rsp;
        logic     want_acks;
        line_st_t fin;
    } lplan_t;

    function automatic lplan_t plan_of(input loc_op_t op, input line_st_t st);
        lplan_t p;
        p = '{send: 1'b0, msg: BM_RD, data: 1'b0, want_rsp: 1'b0,
              want_acks: 1'b0, fin: st};
        case (op)
            OP_LOAD: begin
                if (st == LN_I) begin
                    p.send     = 1'b1;
                    p.msg      = BM_RD;
                    p.want_rsp = 1'b1;
                    p.fin      = LN_S;
                end
            end
            OP_STORE, OP_ATOMIC: begin
                p.fin = LN_M;
                if (st == LN_I) begin
                    p.send      = 1'b1;
                    p.msg       = BM_RDINV;
                    p.want_rsp  = 1'b1;
                    p.want_acks = 1'b1;
                end else if (st == LN_S) begin
                    p.send      = 1'b1;
                    p.msg       = BM_INV;
                    p.want_acks = 1'b1;
                end
            end
            default: begin
                if (st == LN_M) begin
                    p.send = 1'b1;
                    p.msg  = BM_WB;
                    p.data = 1'b1;
                    p.fin  = LN_E;
                end
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/coh_snoop.sv
module coh_snoop
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  bus_msg_t          rx_msg,
    input  logic [ADDR_W-1:0] rx_addr,
    input  line_st_t          rx_state,
    output logic              rx_ready,
    output logic              sn_vld,
    output bus_msg_t          sn_msg,
    output logic [ADDR_W-1:0] sn_addr,
    output logic              sn_data,
    output logic              sn_wr,
    output line_st_t          sn_wr_state
);

    logic              ack_pend_q;
    logic [ADDR_W-1:0] ack_addr_q;
    logic              fire;
    logic              rep_vld;
    bus_msg_t          rep_msg;
    logic              rep_data;
    logic              rep_two;
    logic              wr;
    line_st_t          wr_st;

    assign rx_ready = !ack_pend_q;
    assign fire     = rx_valid && rx_ready;

    always_comb begin
        rep_vld  = 1'b0;
        rep_msg  = BM_INVACK;
        rep_data = 1'b0;
        rep_two  = 1'b0;
        wr       = 1'b0;
        wr_st    = rx_state;
        case (rx_msg)
            BM_RD: begin
                if (rx_state == LN_M || rx_state == LN_E) begin
                    rep_vld  = 1'b1;
                    rep_msg  = BM_RDRSP;
                    rep_data = 1'b1;
                    wr       = 1'b1;
                    wr_st    = LN_S;
                end
            end
            BM_INV: begin
                if (rx_state != LN_I) begin
                    rep_vld = 1'b1;
                    wr      = 1'b1;
                    wr_st   = LN_I;
                end
            end
            BM_RDINV: begin
                if (rx_state == LN_M || rx_state == LN_E) begin
                    rep_vld  = 1'b1;
                    rep_msg  = BM_RDRSP;
                    rep_data = 1'b1;
                    rep_two  = 1'b1;
                    wr       = 1'b1;
                    wr_st    = LN_I;
                end else if (rx_state == LN_S) begin
                    rep_vld = 1'b1;
                    wr      = 1'b1;
                    wr_st   = LN_I;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_pend_q <= 1'b0;
            ack_addr_q <= '0;
        end else begin
            ack_pend_q <= fire && rep_two;
            if (fire) ack_addr_q <= rx_addr;
        end
    end

    assign sn_vld      = ack_pend_q || (fire && rep_vld);
    assign sn_msg      = ack_pend_q ? BM_INVACK : rep_msg;
    assign sn_addr     = ack_pend_q ? ack_addr_q : rx_addr;
    assign sn_data     = ack_pend_q ? 1'b0 : rep_data;
    assign sn_wr       = fire && wr;
    assign sn_wr_state = wr_st;

endmodule

// File: rtl/coh_local.sv
module coh_local
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NPEER  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  loc_op_t           req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  line_st_t          req_state,
    input  logic              rx_fire,
    input  bus_msg_t          rx_msg,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic              take,
    input  logic              tag_busy,
    output logic              busy,
    output logic              lm_pend,
    output bus_msg_t          lm_msg,
    output logic [ADDR_W-1:0] lm_addr,
    output logic              lm_data,
    output logic              cmp,
    output line_st_t          cmp_state
);

    localparam int CNT_W = $clog2(NPEER + 1);

    logic              busy_q;
    logic [ADDR_W-1:0] addr_q;
    lplan_t            plan_q;
    logic              send_q;
    logic              rsp_q;
    logic [CNT_W-1:0]  cnt_q;
    lplan_t            plan_n;
    logic              accept;
    logic              hit;

    assign plan_n = plan_of(req_op, req_state);
    assign accept = req_valid && !busy_q;
    assign hit    = busy_q && rx_fire && (rx_addr == addr_q);
    assign cmp    = busy_q && !send_q && !rsp_q && (cnt_q == '0) && !tag_busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            addr_q <= '0;
            plan_q <= '0;
            send_q <= 1'b0;
            rsp_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            addr_q <= req_addr;
            plan_q <= plan_n;
            send_q <= plan_n.send;
            rsp_q  <= plan_n.want_rsp;
            cnt_q  <= plan_n.want_acks ? CNT_W'(NPEER) : '0;
        end else begin
            if (cmp) busy_q <= 1'b0;
            if (take) send_q <= 1'b0;
            if (hit && rx_msg == BM_RDRSP) rsp_q <= 1'b0;
            if (hit && rx_msg == BM_INVACK && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy      = busy_q;
    assign lm_pend   = busy_q && send_q;
    assign lm_msg    = plan_q.msg;
    assign lm_addr   = addr_q;
    assign lm_data   = plan_q.data;
    assign cmp_state = plan_q.fin;

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
    import coh_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NPEER  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_state,
    output logic              req_ready,
    output logic              req_done,
    output logic              tag_wr_en,
    output logic [ADDR_W-1:0] tag_wr_addr,
    output logic [1:0]        tag_wr_state,
    output logic              tx_valid,
    output logic [2:0]        tx_msg,
    output logic [ADDR_W-1:0] tx_addr,
    output logic              tx_data,
    input  logic              rx_valid,
    input  logic [2:0]        rx_msg,
    input  logic [ADDR_W-1:0] rx_addr,
    input  logic [1:0]        rx_state,
    output logic              rx_ready
);

    logic              sn_vld, sn_data, sn_wr;
    bus_msg_t          sn_msg;
    logic [ADDR_W-1:0] sn_addr;
    line_st_t          sn_wr_state;
    logic              busy, lm_pend, lm_data, cmp, take;
    bus_msg_t          lm_msg;
    logic [ADDR_W-1:0] lm_addr;
    line_st_t          cmp_state;

    coh_snoop #(.ADDR_W(ADDR_W)) snoop_i (
        .clk        (clk),
        .rst        (rst),
        .rx_valid   (rx_valid),
        .rx_msg     (bus_msg_t'(rx_msg)),
        .rx_addr    (rx_addr),
        .rx_state   (line_st_t'(rx_state)),
        .rx_ready   (rx_ready),
        .sn_vld     (sn_vld),
        .sn_msg     (sn_msg),
        .sn_addr    (sn_addr),
        .sn_data    (sn_data),
        .sn_wr      (sn_wr),
        .sn_wr_state(sn_wr_state)
    );

    // Snoop replies own the transmit slot; the local message waits a cycle
    assign take = lm_pend && !sn_vld;

    coh_local #(.ADDR_W(ADDR_W), .NPEER(NPEER)) local_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_op   (loc_op_t'(req_op)),
        .req_addr (req_addr),
        .req_state(line_st_t'(req_state)),
        .rx_fire  (rx_valid && rx_ready),
        .rx_msg   (bus_msg_t'(rx_msg)),
        .rx_addr  (rx_addr),
        .take     (take),
        .tag_busy (sn_wr),
        .busy     (busy),
        .lm_pend  (lm_pend),
        .lm_msg   (lm_msg),
        .lm_addr  (lm_addr),
        .lm_data  (lm_data),
        .cmp      (cmp),
        .cmp_state(cmp_state)
    );

    assign req_ready = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid     <= 1'b0;
            tx_msg       <= '0;
            tx_addr      <= '0;
            tx_data      <= 1'b0;
            tag_wr_en    <= 1'b0;
            tag_wr_addr  <= '0;
            tag_wr_state <= '0;
            req_done     <= 1'b0;
        end else begin
            tx_valid <= sn_vld || take;
            tx_msg   <= sn_vld ? sn_msg  : lm_msg;
            tx_addr  <= sn_vld ? sn_addr : lm_addr;
            tx_data  <= sn_vld ? sn_data : lm_data;
            tag_wr_en    <= sn_wr || cmp;
            tag_wr_addr  <= sn_wr ? rx_addr : lm_addr;
            tag_wr_state <= sn_wr ? sn_wr_state : cmp_state;
            req_done     <= cmp;
        end
    end

endmodule

// File: rtl/coh_ctrl_chk.sv
module coh_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [1:0]        req_op,
    input logic [1:0]        req_state,
    input logic              req_ready,
    input logic              req_done,
    input logic              tag_wr_en,
    input logic [1:0]        tag_wr_state,
    input logic              tx_valid,
    input logic [2:0]        tx_msg,
    input logic              tx_data,
    input logic              rx_valid,
    input logic [2:0]        rx_msg,
    input logic [1:0]        rx_state,
    input logic              rx_ready
);

    logic fire;
    assign fire = rx_valid && rx_ready;

    // R6: two replies, data first, acknowledgment second
    a_r6_rdinv_two_replies: assert property (@(posedge clk) disable iff (rst)
        (fire && rx_msg == 3'd4 && rx_state == 2'd3)
        |=> (tx_valid && tx_msg == 3'd1 && tx_data && !rx_ready) ##1 (tx_valid && tx_msg == 3'd3));

    // R8
    a_r8_inv_on_shared: assert property (@(posedge clk) disable iff (rst)
        (fire && rx_msg == 3'd2 && rx_state == 2'd1)
        |=> (tx_valid && tx_msg == 3'd3 && tag_wr_en && tag_wr_state == 2'd0));

    // R3
    a_r3_silent_upgrade: assert property (@(posedge clk) disable iff (rst)
        ((req_valid && req_ready && req_op == 2'd1 && req_state == 2'd2) ##1 !rx_valid)
        |=> (tag_wr_en && tag_wr_state == 2'd3 && req_done && !tx_valid));

    // R10
    a_r10_ready_with_done: assert property (@(posedge clk) disable iff (rst)
        $rose(req_ready) |-> req_done);

    // R6: receive held off only while the second reply follows a data reply
    a_r6_hold_after_data: assert property (@(posedge clk) disable iff (rst)
        !rx_ready |-> (tx_valid && tx_msg == 3'd1));

endmodule

bind coh_ctrl coh_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_state   (req_state),
    .req_ready   (req_ready),
    .req_done    (req_done),
    .tag_wr_en   (tag_wr_en),
    .tag_wr_state(tag_wr_state),
    .tx_valid    (tx_valid),
    .tx_msg      (tx_msg),
    .tx_data     (tx_data),
    .rx_valid    (rx_valid),
    .rx_msg      (rx_msg),
    .rx_state    (rx_state),
    .rx_ready    (rx_ready)
);

// File: tb/coh_ctrl_tb_top.sv
module coh_ctrl_tb_top;

    localparam int AW = 16;
    localparam int NP = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_state = '0;
    logic          req_ready, req_done, tag_wr_en, tx_valid, tx_data, rx_ready;
    logic [AW-1:0] tag_wr_addr, tx_addr;
    logic [1:0]    tag_wr_state;
    logic [2:0]    tx_msg;
    logic          rx_valid = 1'b0;
    logic [2:0]    rx_msg = '0;
    logic [AW-1:0] rx_addr = '0;
    logic [1:0]    rx_state = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    coh_ctrl #(.ADDR_W(AW), .NPEER(NP)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr), .req_state(req_state),
        .req_ready(req_ready), .req_done(req_done),
        .tag_wr_en(tag_wr_en), .tag_wr_addr(tag_wr_addr), .tag_wr_state(tag_wr_state),
        .tx_valid(tx_valid), .tx_msg(tx_msg), .tx_addr(tx_addr), .tx_data(tx_data),
        .rx_valid(rx_valid), .rx_msg(rx_msg), .rx_addr(rx_addr), .rx_state(rx_state),
        .rx_ready(rx_ready)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [1:0] st);
        req_valid = 1'b1; req_op = op; req_addr = a; req_state = st;
        step();
        req_valid = 1'b0;
    endtask

    task automatic snoop(input logic [2:0] m, input logic [AW-1:0] a, input logic [1:0] st);
        rx_valid = 1'b1; rx_msg = m; rx_addr = a; rx_state = st;
        step();
        rx_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 tx_valid", tx_valid, 0);
        check("R1 tag_wr_en", tag_wr_en, 0);
        check("R1 req_done", req_done, 0);
        check("R1 req_ready", req_ready, 1);
        check("R1 rx_ready", rx_ready, 1);
    endtask

    task automatic t_load_miss();
        issue(2'd0, 16'h0100, 2'd0);
        check("R10 busy after accept", req_ready, 0);
        step();
        check("R2 read sent", {tx_valid, tx_msg, tx_addr}, {1'b1, 3'd0, 16'h0100});
        snoop(3'd1, 16'h0100, 2'd0);
        check("R2 not done at response edge", req_done, 0);
        check("R10 still busy", req_ready, 0);
        step();
        check("R2 done", {req_done, tag_wr_en, tag_wr_state, tag_wr_addr}, {1'b1, 1'b1, 2'd1, 16'h0100});
        check("R10 ready with done", req_ready, 1);
    endtask

    task automatic t_store_excl();
        issue(2'd1, 16'h0200, 2'd2);
        step();
        check("R3 done to M", {req_done, tag_wr_en, tag_wr_state}, {1'b1, 1'b1, 2'd3});
        check("R3 no bus traffic", tx_valid, 0);
    endtask

    task automatic t_store_miss();
        issue(2'd1, 16'h0300, 2'd0);
        step();
        check("R4 rdinv sent", {tx_valid, tx_msg, tx_addr}, {1'b1, 3'd4, 16'h0300});
        snoop(3'd3, 16'h0300, 2'd0);
        snoop(3'd3, 16'h0999, 2'd0);
        snoop(3'd1, 16'h0300, 2'd0);
        snoop(3'd3, 16'h0300, 2'd0);
        snoop(3'd3, 16'h0999, 2'd0);
        step();
        check("R10 foreign acks not counted", req_done, 0);
        snoop(3'd3, 16'h0300, 2'd0);
        check("R4 not done at last ack edge", req_done, 0);
        step();
        check("R4 done to M", {req_done, tag_wr_state, tag_wr_addr}, {1'b1, 2'd3, 16'h0300});
    endtask

    task automatic t_atomic_shared();
        issue(2'd2, 16'h0400, 2'd1);
        step();
        check("R5 invalidate sent", {tx_valid, tx_msg}, {1'b1, 3'd2});
        snoop(3'd3, 16'h0400, 2'd1);
        snoop(3'd3, 16'h0400, 2'd1);
        step();
        check("R5 waits for all acks", req_done, 0);
        snoop(3'd3, 16'h0400, 2'd1);
        step();
        check("R5 done to M", {req_done, tag_wr_state}, {1'b1, 2'd3});
    endtask

    task automatic t_snoop_rdinv();
        snoop(3'd4, 16'h0500, 2'd3);
        check("R6 data reply", {tx_valid, tx_msg, tx_data}, {1'b1, 3'd1, 1'b1});
        check("R6 line to I", {tag_wr_en, tag_wr_state, tag_wr_addr}, {1'b1, 2'd0, 16'h0500});
        check("R6 rx held", rx_ready, 0);
        step();
        check("R6 ack follows", {tx_valid, tx_msg, tx_addr}, {1'b1, 3'd3, 16'h0500});
        check("R6 rx released", rx_ready, 1);
    endtask

    task automatic t_snoop_read();
        snoop(3'd0, 16'h0600, 2'd2);
        check("R7 read on E replies", {tx_valid, tx_msg, tx_data}, {1'b1, 3'd1, 1'b1});
        check("R7 line to S", {tag_wr_en, tag_wr_state}, {1'b1, 2'd1});
        snoop(3'd0, 16'h0601, 2'd1);
        check("R7 read on S silent", {tx_valid, tag_wr_en}, {1'b0, 1'b0});
    endtask

    task automatic t_snoop_inv();
        snoop(3'd2, 16'h0700, 2'd1);
        check("R8 ack", {tx_valid, tx_msg}, {1'b1, 3'd3});
        check("R8 line to I", {tag_wr_en, tag_wr_state}, {1'b1, 2'd0});
    endtask

    task automatic t_flush();
        issue(2'd3, 16'h0800, 2'd3);
        step();
        check("R9 writeback", {tx_valid, tx_msg, tx_data}, {1'b1, 3'd5, 1'b1});
        step();
        check("R9 done to E", {req_done, tag_wr_state}, {1'b1, 2'd2});
    endtask

    task automatic t_overlap();
        issue(2'd0, 16'h0900, 2'd0);
        snoop(3'd0, 16'h0A00, 2'd3);
        check("R11 snoop reply first", {tx_valid, tx_msg, tx_addr}, {1'b1, 3'd1, 16'h0A00});
        step();
        check("R11 local read next", {tx_valid, tx_msg, tx_addr}, {1'b1, 3'd0, 16'h0900});
        snoop(3'd1, 16'h0900, 2'd0);
        step();
        check("R11 local completes", {req_done, tag_wr_state}, {1'b1, 2'd1});
    endtask

    task automatic t_hits();
        issue(2'd0, 16'h0B00, 2'd2);
        step();
        check("R12 load hit", {req_done, tag_wr_state, tx_valid}, {1'b1, 2'd2, 1'b0});
        issue(2'd2, 16'h0B01, 2'd3);
        step();
        check("R12 atomic on M", {req_done, tag_wr_state, tx_valid}, {1'b1, 2'd3, 1'b0});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_load_miss();
        t_store_excl();
        t_store_miss();
        t_atomic_shared();
        t_snoop_rdinv();
        t_snoop_read();
        t_snoop_inv();
        t_flush();
        t_overlap();
        t_hits();
        step();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule